// File: doc/BRIEF.md
# EEPROM Transaction Sequencer

This block stands between a processor's port writes and a byte-level I2C master engine, and it assembles complete serial-EEPROM transactions from queued bytes. Software loads the memory-address bytes, and for a write the data bytes, into a small byte queue. It then strobes an arm port and after that a start port. The two start ports pick the direction. While a transaction runs, the sequencer holds the engine's enable asserted. It presents the fixed device address 1010000 with the chosen R/W bit, and it hands the engine a fresh queued byte each time the engine asks for one.

The transaction ends when the queue is empty, not when a byte counter runs out. If the engine asks for the next byte and the queue holds nothing, the sequencer releases enable, and the engine closes the bus with a stop. The same happens on an acknowledge error. On a read, each byte the engine returns is latched into a register that software can read. Software can also read flags for queue full, queue empty, busy, error and overflow, plus the low four bits of the queue write pointer.

Top module: `eeprom_seq`

## Requirements
- R1: After a synchronous reset: enable is low, the queue is empty and not full, the pointer is 0, the error and overflow flags are clear, busy is low and the read byte is 0.
- R2: The device address output is always 7'b1010000. A start through the write port sets the R/W output to 0, a start through the read port sets it to 1, and R/W stays stable while enable is high.
- R3: A start strobe is accepted only if an arm strobe came before it. Each arm permits exactly one start. A start without an arm leaves enable low.
- R4: One cycle after an accepted write start, enable is high and the oldest queued byte is on the write-byte output.
- R5: Each engine request while enable is high, with the queue not empty, pops the next byte onto the write-byte output one cycle later. Bytes leave in the order in which they were pushed.
- R6: An engine request while enable is high and the queue is empty drops enable one cycle later. Otherwise, enable stays high until an error occurs.
- R7: An accepted read start pops nothing. Each request that arrives while the engine reports busy, in a read, loads the engine's returned byte into the read-byte output one cycle later. Each such request also consumes one queued byte, so k queued bytes give k+1 returned bytes.
- R8: An engine error while enable is high drops enable one cycle later and sets a sticky error flag. The next arm strobe clears the flag.
- R9: The queue holds 16 bytes and reports full at 16. A push while the queue is full is dropped and sets a sticky overflow flag, which the next arm strobe clears.
- R10: The pointer output is the queue write pointer modulo 16, counting only accepted pushes. Busy is high when enable is high or the engine reports busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_push | input | 1 | Push strobe for the byte queue |
| cpu_byte | input | 8 | Byte to push |
| cpu_arm | input | 1 | Arm strobe, required before each start |
| cpu_go_wr | input | 1 | Start strobe for a write transaction |
| cpu_go_rd | input | 1 | Start strobe for a read transaction |
| rd_byte | output | 8 | Last byte returned in a read |
| st_full | output | 1 | Queue full |
| st_empty | output | 1 | Queue empty |
| st_busy | output | 1 | Transaction in progress |
| st_err | output | 1 | Sticky acknowledge error |
| st_ovf | output | 1 | Sticky dropped-push flag |
| st_ptr | output | 4 | Low four bits of the queue write pointer |
| eng_ena | output | 1 | Engine enable; releasing it makes the engine send a stop |
| eng_dev | output | 7 | Device address for the engine |
| eng_rw | output | 1 | R/W bit for the engine, 1 = read |
| eng_wbyte | output | 8 | Byte the engine transmits next |
| eng_req | input | 1 | One-cycle pulse from the engine requesting the next byte |
| eng_busy | input | 1 | Engine busy |
| eng_rbyte | input | 8 | Byte returned by the engine |
| eng_err | input | 1 | One-cycle pulse from the engine on a missing acknowledge |

## Verification
The bench builds the block with its default 16-entry queue. At that depth every possible write length fits: the sweep covers an address-only pointer set and all data lengths from 0 to 14, so each queue occupancy from 2 to 16 is seen draining in order. The small depth also makes the full and overflow edge cheap to reach. The same holds for a wrap of the write pointer through zero. Reads with 0 to 3 queued dummy bytes, an error in the middle of a transaction, and starts without an arm cover the remaining control paths.

// File: rtl/eeseq_pkg.sv
package eeseq_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam logic [6:0] EEPROM_DEV_DEFAULT = 7'b1010000;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic {
        DIR_WRITE = 1'b0,
        DIR_READ  = 1'b1
    } dir_e;

    typedef struct packed {
        logic err;
        logic ovf;
    } sticky_t;

    // direction chosen by the start strobes; write wins if both are seen
    function automatic dir_e pick_dir(input logic go_wr);
        return go_wr ? DIR_WRITE : DIR_READ;
    endfunction

endpackage

// File: rtl/eeseq_queue.sv
module eeseq_queue
    import eeseq_pkg::*;
#(
    parameter int unsigned DEPTH = 16
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      push,
    input  byte_t                     push_data,
    input  logic                      pop,
    output byte_t                     head,
    output logic                      full,
    output logic                      empty,
    output logic [$clog2(DEPTH)-1:0]  wptr
);
    localparam int unsigned AW    = $clog2(DEPTH);
    localparam int unsigned CNT_W = AW + 1;

    byte_t            mem [DEPTH];
    logic [AW-1:0]    rptr;
    logic [CNT_W-1:0] count;
    logic             push_ok;
    logic             pop_ok;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign head    = mem[rptr];

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push_ok) wptr <= bump(wptr);
            if (pop_ok)  rptr <= bump(rptr);
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    a_r9_never_full_and_empty: assert property (@(posedge clk) disable iff (rst)
        !(full && empty));

    a_r9_full_push_dropped: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop) |=> (count == $past(count)));

    a_r5_pop_lowers_count: assert property (@(posedge clk) disable iff (rst)
        (pop && !empty && !push) |=> (count == $past(count) - 1'b1));

endmodule

// File: rtl/eeseq_ctrl.sv
module eeseq_ctrl
    import eeseq_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    arm_stb,
    input  logic    go_wr_stb,
    input  logic    go_rd_stb,
    input  logic    push,
    input  logic    q_empty,
    input  logic    q_full,
    input  logic    eng_req,
    input  logic    eng_busy,
    input  logic    eng_err,
    output logic    ena,
    output dir_e    dir,
    output logic    pop,
    output logic    capture,
    output sticky_t flags
);
    logic armed;
    logic start_ok;
    dir_e start_dir;
    logic stop_now;

    assign start_ok  = armed && !ena && (go_wr_stb || go_rd_stb);
    assign start_dir = pick_dir(go_wr_stb);
    assign stop_now  = ena && (eng_err || (eng_req && q_empty));

    // a write start preloads the first byte; each later request fetches one
    assign pop = (start_ok && (start_dir == DIR_WRITE) && !q_empty)
              || (ena && eng_req && !eng_err && !q_empty);

    assign capture = eng_req && eng_busy && (dir == DIR_READ);

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
            ena   <= 1'b0;
            dir   <= DIR_WRITE;
            flags <= '0;
        end else begin
            if (arm_stb)       armed <= 1'b1;
            else if (start_ok) armed <= 1'b0;

            if (start_ok) begin
                ena <= 1'b1;
                dir <= start_dir;
            end else if (stop_now) begin
                ena <= 1'b0;
            end

            if (arm_stb)                flags.err <= 1'b0;
            else if (ena && eng_err)    flags.err <= 1'b1;

            if (arm_stb)                flags.ovf <= 1'b0;
            else if (push && q_full)    flags.ovf <= 1'b1;
        end
    end

    a_r3_start_needs_arm: assert property (@(posedge clk) disable iff (rst)
        $rose(ena) |-> $past(armed));

    a_r6_drop_has_cause: assert property (@(posedge clk) disable iff (rst)
        $fell(ena) |-> $past(eng_err || (eng_req && q_empty)));

    a_r2_dir_stable: assert property (@(posedge clk) disable iff (rst)
        (ena && $past(ena)) |-> $stable(dir));

    a_r8_err_sticks: assert property (@(posedge clk) disable iff (rst)
        (ena && eng_err && !arm_stb) |=> (flags.err && !ena));

endmodule

// File: rtl/eeseq_bytes.sv
module eeseq_bytes
    import eeseq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load_w,
    input  byte_t head,
    input  logic  capture,
    input  byte_t eng_rbyte,
    output byte_t wbyte,
    output byte_t rbyte
);
    always_ff @(posedge clk) begin
        if (rst) begin
            wbyte <= '0;
            rbyte <= '0;
        end else begin
            if (load_w)  wbyte <= head;
            if (capture) rbyte <= eng_rbyte;
        end
    end

    a_r7_capture_lands: assert property (@(posedge clk) disable iff (rst)
        capture |=> (rbyte == $past(eng_rbyte)));

    a_r5_load_lands: assert property (@(posedge clk) disable iff (rst)
        load_w |=> (wbyte == $past(head)));

endmodule

// File: rtl/eeprom_seq.sv
module eeprom_seq
    import eeseq_pkg::*;
#(
    parameter int unsigned DEPTH   = 16,
    parameter logic [6:0]  DEV_ADR = EEPROM_DEV_DEFAULT
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cpu_push,
    input  logic [7:0] cpu_byte,
    input  logic       cpu_arm,
    input  logic       cpu_go_wr,
    input  logic       cpu_go_rd,
    output logic [7:0] rd_byte,
    output logic       st_full,
    output logic       st_empty,
    output logic       st_busy,
    output logic       st_err,
    output logic       st_ovf,
    output logic [3:0] st_ptr,
    output logic       eng_ena,
    output logic [6:0] eng_dev,
    output logic       eng_rw,
    output logic [7:0] eng_wbyte,
    input  logic       eng_req,
    input  logic       eng_busy,
    input  logic [7:0] eng_rbyte,
    input  logic       eng_err
);
    localparam int unsigned AW = $clog2(DEPTH);

    byte_t         head;
    logic          q_full;
    logic          q_empty;
    logic [AW-1:0] wptr;
    logic          pop;
    logic          capture;
    dir_e          dir;
    sticky_t       flags;

    eeseq_queue #(.DEPTH(DEPTH)) i_queue (
        .clk       (clk),
        .rst       (rst),
        .push      (cpu_push),
        .push_data (cpu_byte),
        .pop       (pop),
        .head      (head),
        .full      (q_full),
        .empty     (q_empty),
        .wptr      (wptr)
    );

    eeseq_ctrl i_ctrl (
        .clk       (clk),
        .rst       (rst),
        .arm_stb   (cpu_arm),
        .go_wr_stb (cpu_go_wr),
        .go_rd_stb (cpu_go_rd),
        .push      (cpu_push),
        .q_empty   (q_empty),
        .q_full    (q_full),
        .eng_req   (eng_req),
        .eng_busy  (eng_busy),
        .eng_err   (eng_err),
        .ena       (eng_ena),
        .dir       (dir),
        .pop       (pop),
        .capture   (capture),
        .flags     (flags)
    );

    eeseq_bytes i_bytes (
        .clk       (clk),
        .rst       (rst),
        .load_w    (pop),
        .head      (head),
        .capture   (capture),
        .eng_rbyte (eng_rbyte),
        .wbyte     (eng_wbyte),
        .rbyte     (rd_byte)
    );

    generate
        if (AW >= 4) begin : g_ptr_wide
            assign st_ptr = wptr[3:0];
        end else begin : g_ptr_narrow
            assign st_ptr = {{(4 - AW){1'b0}}, wptr};
        end
    endgenerate

    assign eng_dev  = DEV_ADR;
    assign eng_rw   = (dir == DIR_READ);
    assign st_full  = q_full;
    assign st_empty = q_empty;
    assign st_busy  = eng_ena || eng_busy;
    assign st_err   = flags.err;
    assign st_ovf   = flags.ovf;

    a_r2_fixed_device: assert property (@(posedge clk) disable iff (rst)
        eng_dev == 7'b1010000);

    a_r10_busy_covers_ena: assert property (@(posedge clk) disable iff (rst)
        eng_ena |-> st_busy);

endmodule

// File: tb/test_eeprom_seq.sv
module test_eeprom_seq;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       cpu_push, cpu_arm, cpu_go_wr, cpu_go_rd;
    logic [7:0] cpu_byte;
    logic [7:0] rd_byte;
    logic       st_full, st_empty, st_busy, st_err, st_ovf;
    logic [3:0] st_ptr;
    logic       eng_ena, eng_rw;
    logic [6:0] eng_dev;
    logic [7:0] eng_wbyte;
    logic       eng_req, eng_busy, eng_err;
    logic [7:0] eng_rbyte;

    int total = 0;
    int bad   = 0;
    int accepted = 0;
    int occupancy = 0;
    logic [7:0] vals [20];

    always #(CLK_PERIOD / 2) clk = ~clk;

    eeprom_seq i_eeprom_seq (
        .clk(clk), .rst(rst),
        .cpu_push(cpu_push), .cpu_byte(cpu_byte), .cpu_arm(cpu_arm),
        .cpu_go_wr(cpu_go_wr), .cpu_go_rd(cpu_go_rd),
        .rd_byte(rd_byte), .st_full(st_full), .st_empty(st_empty),
        .st_busy(st_busy), .st_err(st_err), .st_ovf(st_ovf), .st_ptr(st_ptr),
        .eng_ena(eng_ena), .eng_dev(eng_dev), .eng_rw(eng_rw),
        .eng_wbyte(eng_wbyte), .eng_req(eng_req), .eng_busy(eng_busy),
        .eng_rbyte(eng_rbyte), .eng_err(eng_err)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%0h expected=%0h at %0t", req, got, exp, $time);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic push(input logic [7:0] b);
        cpu_push = 1'b1; cpu_byte = b;
        cyc();
        cpu_push = 1'b0;
        if (occupancy < 16) begin
            occupancy++;
            accepted++;
        end
    endtask

    task automatic arm();
        cpu_arm = 1'b1; cyc(); cpu_arm = 1'b0;
    endtask

    task automatic go_wr();
        cpu_go_wr = 1'b1; cyc(); cpu_go_wr = 1'b0;
    endtask

    task automatic go_rd();
        cpu_go_rd = 1'b1; cyc(); cpu_go_rd = 1'b0;
    endtask

    task automatic request(input logic busy, input logic [7:0] rb);
        eng_req = 1'b1; eng_busy = busy; eng_rbyte = rb;
        cyc();
        eng_req = 1'b0; eng_busy = 1'b0;
    endtask

    // write of len queued bytes, values in vals[]
    task automatic write_run(input int len);
        for (int i = 0; i < len; i++) push(vals[i]);
        check("R10 ptr after pushes", {28'd0, st_ptr}, accepted % 16);
        arm();
        go_wr();
        if (occupancy > 0) occupancy--;
        check("R4 ena after write start", {31'd0, eng_ena}, 1);
        check("R2 rw write", {31'd0, eng_rw}, 0);
        check("R4 first byte", {24'd0, eng_wbyte}, vals[0]);
        for (int i = 1; i < len; i++) begin
            request(1'b0, 8'h00);
            occupancy--;
            check("R5 next byte in order", {24'd0, eng_wbyte}, vals[i]);
            check("R6 ena held", {31'd0, eng_ena}, 1);
        end
        request(1'b0, 8'h00);
        check("R6 ena dropped on empty", {31'd0, eng_ena}, 0);
        check("R6 queue empty at end", {31'd0, st_empty}, 1);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1;
        cpu_push = 0; cpu_arm = 0; cpu_go_wr = 0; cpu_go_rd = 0; cpu_byte = 0;
        eng_req = 0; eng_busy = 0; eng_err = 0; eng_rbyte = 0;
        repeat (3) cyc();
        rst = 1'b0;
        cyc();

        // R1 reset state
        check("R1 ena", {31'd0, eng_ena}, 0);
        check("R1 empty", {31'd0, st_empty}, 1);
        check("R1 full", {31'd0, st_full}, 0);
        check("R1 ptr", {28'd0, st_ptr}, 0);
        check("R1 err", {31'd0, st_err}, 0);
        check("R1 ovf", {31'd0, st_ovf}, 0);
        check("R1 busy", {31'd0, st_busy}, 0);
        check("R1 rd_byte", {24'd0, rd_byte}, 0);
        check("R2 device address", {25'd0, eng_dev}, 7'b1010000);

        // R3 starts without arm are ignored
        go_wr();
        check("R3 unarmed write start", {31'd0, eng_ena}, 0);
        go_rd();
        check("R3 unarmed read start", {31'd0, eng_ena}, 0);

        // R10 busy follows engine busy
        eng_busy = 1'b1;
        #1;
        check("R10 busy from engine", {31'd0, st_busy}, 1);
        eng_busy = 1'b0;
        cyc();

        // sweep: address-only and 0..14 data bytes
        for (int n = 0; n <= 14; n++) begin
            for (int i = 0; i < n + 2; i++) vals[i] = 8'((n * 16 + i * 7 + 3) & 255);
            write_run(n + 2);
        end

        // R3 arm consumed by the previous start
        go_wr();
        check("R3 arm consumed", {31'd0, eng_ena}, 0);

        // reads with k dummy bytes
        for (int k = 0; k <= 3; k++) begin
            for (int i = 0; i < k; i++) push(8'hEE);
            arm();
            go_rd();
            check("R2 rw read", {31'd0, eng_rw}, 1);
            check("R7 ena after read start", {31'd0, eng_ena}, 1);
            check("R7 read start pops nothing", {31'd0, st_empty}, (k == 0) ? 1 : 0);
            for (int j = 0; j <= k; j++) begin
                request(1'b1, 8'(8'hA0 + j * 5 + k));
                if (occupancy > 0) occupancy--;
                check("R7 returned byte latched", {24'd0, rd_byte}, 8'(8'hA0 + j * 5 + k));
                check("R7 ena during read", {31'd0, eng_ena}, (j < k) ? 1 : 0);
            end
        end

        // R9 overflow
        for (int i = 0; i < 17; i++) begin
            vals[i] = 8'(i * 3 + 1);
            push(vals[i]);
        end
        check("R9 full at 16", {31'd0, st_full}, 1);
        check("R9 overflow flag", {31'd0, st_ovf}, 1);
        check("R10 ptr wraps", {28'd0, st_ptr}, accepted % 16);
        arm();
        check("R9 overflow cleared by arm", {31'd0, st_ovf}, 0);
        go_wr();
        occupancy--;
        check("R9 first of full queue", {24'd0, eng_wbyte}, vals[0]);
        for (int i = 1; i < 16; i++) begin
            request(1'b0, 8'h00);
            occupancy--;
            check("R9 full queue order", {24'd0, eng_wbyte}, vals[i]);
        end
        request(1'b0, 8'h00);
        check("R9 seventeenth byte dropped", {31'd0, eng_ena}, 0);

        // R8 error mid-transaction
        vals[0] = 8'h11; vals[1] = 8'h22; vals[2] = 8'h33;
        for (int i = 0; i < 3; i++) push(vals[i]);
        arm();
        go_wr();
        occupancy--;
        eng_err = 1'b1; cyc(); eng_err = 1'b0;
        check("R8 ena dropped on error", {31'd0, eng_ena}, 0);
        check("R8 error flag set", {31'd0, st_err}, 1);
        check("R8 error pops nothing", {31'd0, st_empty}, 0);
        arm();
        check("R8 error cleared by arm", {31'd0, st_err}, 0);
        go_wr();
        check("R8 resume with next byte", {24'd0, eng_wbyte}, 8'h22);
        request(1'b0, 8'h00);
        check("R8 last byte", {24'd0, eng_wbyte}, 8'h33);
        request(1'b0, 8'h00);
        check("R8 ends on empty", {31'd0, eng_ena}, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule